// File: doc/BRIEF.md
# Dual-Channel Host Mailbox Buffer

This block is a parallel mailbox that sits between an external master processor and a local slave processor. It has two identical, independent channels. For each channel the master can post a byte into an inbound register and fetch a byte from an outbound register. The master can also read a status byte that shows whether each direction is occupied and whether the last inbound byte was a command or data. The master drives an active-low chip select per channel, shared active-low read and write strobes, an address line A0, and an 8-bit data bus. The slave reaches the registers over a simple synchronous register bus.

The master strobes are asynchronous to the slave clock. A two-flop synchronizer brings them into the slave clock domain. A small strobe state machine per channel then turns each strobe into a single completion pulse on the strobe's deasserting (trailing) edge. That pulse updates the flags once per access, no matter how long the strobe is held. The A0 level sampled on a master write tags the byte as a command (A0 = 1) or as data (A0 = 0). The tag is kept in the status byte. A control bit in each channel decides whether command writes raise the slave interrupt as well as data writes. Each channel also drives two indicator pins, one for a full outbound register and one for a full inbound register.

Strobe state machine states and transitions, per channel:

- STB_IDLE → STB_WRITE when the synchronized write strobe is active.
- STB_IDLE → STB_READ when the synchronized read strobe is active and no write is active.
- STB_WRITE → STB_IDLE when the write strobe is released. This transition emits the write-done pulse.
- STB_READ → STB_IDLE when the read strobe is released. This transition emits the read-done pulse.

The master must hold its data bus and A0 stable until SYNC_STAGES + 3 clock cycles after it releases a strobe.

Slave register map. Channel c starts at base address 4·c:

| Offset | Register | Read | Write |
|---|---|---|---|
| 0 | Data | Inbound byte | Outbound byte |
| 1 | Status | Status byte | General-purpose bits only |
| 2 | Control | Interrupt-select bit in bit 0, other bits 0 | Interrupt-select bit from bit 0 |

Top module: `host_mailbox`

## Requirements
- R1: After reset, every register reads 0x00. The indicator pins, the interrupts and hst_doe are all low.
- R2: A completed master write to channel c stores hst_din in that channel's inbound register. The slave reads it at offset 0.
- R3: Each completed master write copies its A0 level into status bit 3. Bit 3 = 1 means a command and bit 3 = 0 means data.
- R4: Status bit 1 (inbound full) and pin ibf_pin[c] set when a master write completes. They clear when the slave reads offset 0. If both happen in the same cycle, the set wins.
- R5: Status bit 0 (outbound full) and pin obf_pin[c] set when the slave writes offset 0. They clear when a master read with A0 = 0 completes.
- R6: While hst_cs_n[c] and hst_rd_n are both low, hst_doe is high. hst_dout then carries the status byte if A0 = 1, or the outbound register if A0 = 0.
- R7: A slave write to offset 1 changes only status bits 2 and 4 to 7. Bits 0, 1 and 3 ignore it.
- R8: A completed master write gives a one-cycle pulse on loc_irq[c]. With control bit 0 = 0, both data and command writes pulse. With control bit 0 = 1, only data writes (A0 = 0) pulse.
- R9: An access to one channel leaves the other channel's registers, pins and interrupt unchanged.
- R10: Each strobe, however long, updates the flags and the interrupt exactly once. A master status read (A0 = 1) does not clear the outbound-full flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_cs_n | input | CHANNELS | Master chip select per channel, active low |
| hst_rd_n | input | 1 | Master read strobe, active low |
| hst_wr_n | input | 1 | Master write strobe, active low |
| hst_a0 | input | 1 | Master address line: 1 = status/command, 0 = data |
| hst_din | input | 8 | Master write data |
| hst_dout | output | 8 | Master read data |
| hst_doe | output | 1 | Master read data valid (drive enable) |
| loc_addr | input | ADDR_W | Slave register address |
| loc_wr | input | 1 | Slave write strobe, one cycle |
| loc_rd | input | 1 | Slave read strobe, one cycle |
| loc_wdata | input | 8 | Slave write data |
| loc_rdata | output | 8 | Slave read data, combinational |
| loc_irq | output | CHANNELS | Inbound interrupt pulse per channel |
| obf_pin | output | CHANNELS | Outbound-full indicator per channel |
| ibf_pin | output | CHANNELS | Inbound-full indicator per channel |

## Verification
The bench builds the block with the default parameters: CHANNELS = 2 and SYNC_STAGES = 2. Two channels make cross-channel isolation observable. A two-stage synchronizer keeps the completion latency short, so strobes can be held for one cycle or for many. This exercises the single-update-per-strobe rule, both settings of the interrupt-select bit with both A0 levels, and the difference between a status read and a data read on the master side.

// File: rtl/hmbx_pkg.sv
package hmbx_pkg;
    typedef enum logic [1:0] {
        STB_IDLE  = 2'd0,
        STB_WRITE = 2'd1,
        STB_READ  = 2'd2
    } stb_state_t;

    localparam int STAT_OBF = 0;
    localparam int STAT_IBF = 1;
    localparam int STAT_CMD = 3;
    localparam logic [7:0] STAT_RO_MASK = 8'b0000_1011;

    localparam int OFS_DATA = 0;
    localparam int OFS_STAT = 1;
    localparam int OFS_CTRL = 2;
    localparam int CH_SPAN  = 4;
endpackage

// File: rtl/hmbx_sync.sv
module hmbx_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hmbx_strobe_fsm.sv
module hmbx_strobe_fsm
    import hmbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_act,
    input  logic rd_act,
    output logic wr_done,
    output logic rd_done
);
    stb_state_t state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= STB_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            STB_IDLE: begin
                if (wr_act)      state_nxt = STB_WRITE;
                else if (rd_act) state_nxt = STB_READ;
            end
            STB_WRITE: if (!wr_act) state_nxt = STB_IDLE;
            STB_READ:  if (!rd_act) state_nxt = STB_IDLE;
            default:   state_nxt = STB_IDLE;
        endcase
    end

    always_comb begin
        wr_done = 1'b0;
        rd_done = 1'b0;
        unique case (state)
            STB_WRITE: wr_done = !wr_act;
            STB_READ:  rd_done = !rd_act;
            default: ;
        endcase
    end

    // R10: a completion pulse never lasts two cycles
    p_wr_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done);
    p_rd_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);
endmodule

// File: rtl/hmbx_channel.sv
module hmbx_channel
    import hmbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_done,
    input  logic       rd_done,
    input  logic [7:0] hst_din,
    input  logic       hst_a0,
    input  logic       slv_data_wr,
    input  logic       slv_data_rd,
    input  logic       slv_stat_wr,
    input  logic       slv_ctrl_wr,
    input  logic [7:0] slv_wdata,
    output logic [7:0] in_byte,
    output logic [7:0] out_byte,
    output logic [7:0] status,
    output logic       irq_sel,
    output logic       irq,
    output logic       obf,
    output logic       ibf
);
    logic       cmd_flag;
    logic [7:0] gp_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_byte  <= '0;
            out_byte <= '0;
            cmd_flag <= 1'b0;
            gp_bits  <= '0;
            irq_sel  <= 1'b0;
            irq      <= 1'b0;
            obf      <= 1'b0;
            ibf      <= 1'b0;
        end else begin
            if (wr_done) begin
                in_byte  <= hst_din;
                cmd_flag <= hst_a0;
                ibf      <= 1'b1;
            end else if (slv_data_rd) begin
                ibf <= 1'b0;
            end
            if (slv_data_wr) begin
                out_byte <= slv_wdata;
                obf      <= 1'b1;
            end else if (rd_done && !hst_a0) begin
                obf <= 1'b0;
            end
            if (slv_stat_wr) gp_bits <= slv_wdata & ~STAT_RO_MASK;
            if (slv_ctrl_wr) irq_sel <= slv_wdata[0];
            irq <= wr_done && (!irq_sel || !hst_a0);
        end
    end

    always_comb begin
        status           = gp_bits;
        status[STAT_OBF] = obf;
        status[STAT_IBF] = ibf;
        status[STAT_CMD] = cmd_flag;
    end

    p_ibf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> ibf);
    p_obf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        slv_data_wr |=> obf);
    p_ro_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_stat_wr && !wr_done && !rd_done && !slv_data_wr && !slv_data_rd)
        |=> ((status & STAT_RO_MASK) == $past(status & STAT_RO_MASK)));
    p_irq_cmd_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && hst_a0 && irq_sel) |=> !irq);
    p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    p_stat_read_keeps_obf_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && hst_a0 && obf) |=> obf);
endmodule

// File: rtl/host_mailbox.sv
module host_mailbox
    import hmbx_pkg::*;
#(
    parameter int CHANNELS    = 2,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = $clog2(CHANNELS * CH_SPAN)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CHANNELS-1:0] hst_cs_n,
    input  logic                hst_rd_n,
    input  logic                hst_wr_n,
    input  logic                hst_a0,
    input  logic [7:0]          hst_din,
    output logic [7:0]          hst_dout,
    output logic                hst_doe,
    input  logic [ADDR_W-1:0]   loc_addr,
    input  logic                loc_wr,
    input  logic                loc_rd,
    input  logic [7:0]          loc_wdata,
    output logic [7:0]          loc_rdata,
    output logic [CHANNELS-1:0] loc_irq,
    output logic [CHANNELS-1:0] obf_pin,
    output logic [CHANNELS-1:0] ibf_pin
);
    logic [7:0] in_v   [CHANNELS];
    logic [7:0] out_v  [CHANNELS];
    logic [7:0] stat_v [CHANNELS];
    logic       sel_v  [CHANNELS];

    for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
        logic [1:0] act_raw, act_sync;
        logic       wr_done, rd_done;
        logic       hit_data, hit_stat, hit_ctrl;

        assign act_raw  = {!hst_cs_n[c] && !hst_wr_n, !hst_cs_n[c] && !hst_rd_n};
        assign hit_data = (loc_addr == ADDR_W'(c * CH_SPAN + OFS_DATA));
        assign hit_stat = (loc_addr == ADDR_W'(c * CH_SPAN + OFS_STAT));
        assign hit_ctrl = (loc_addr == ADDR_W'(c * CH_SPAN + OFS_CTRL));

        hmbx_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) i_sync (
            .clk(clk), .rst_n(rst_n), .d(act_raw), .q(act_sync)
        );

        hmbx_strobe_fsm i_fsm (
            .clk(clk), .rst_n(rst_n),
            .wr_act(act_sync[1]), .rd_act(act_sync[0]),
            .wr_done(wr_done), .rd_done(rd_done)
        );

        hmbx_channel i_chan (
            .clk(clk), .rst_n(rst_n),
            .wr_done(wr_done), .rd_done(rd_done),
            .hst_din(hst_din), .hst_a0(hst_a0),
            .slv_data_wr(loc_wr && hit_data),
            .slv_data_rd(loc_rd && hit_data),
            .slv_stat_wr(loc_wr && hit_stat),
            .slv_ctrl_wr(loc_wr && hit_ctrl),
            .slv_wdata(loc_wdata),
            .in_byte(in_v[c]), .out_byte(out_v[c]), .status(stat_v[c]),
            .irq_sel(sel_v[c]), .irq(loc_irq[c]),
            .obf(obf_pin[c]), .ibf(ibf_pin[c])
        );
    end

    always_comb begin
        loc_rdata = '0;
        for (int c = 0; c < CHANNELS; c++) begin
            if (loc_addr == ADDR_W'(c * CH_SPAN + OFS_DATA)) loc_rdata = in_v[c];
            if (loc_addr == ADDR_W'(c * CH_SPAN + OFS_STAT)) loc_rdata = stat_v[c];
            if (loc_addr == ADDR_W'(c * CH_SPAN + OFS_CTRL)) loc_rdata = {7'b0, sel_v[c]};
        end
    end

    always_comb begin
        hst_dout = '0;
        for (int c = CHANNELS - 1; c >= 0; c--) begin
            if (!hst_cs_n[c]) hst_dout = hst_a0 ? stat_v[c] : out_v[c];
        end
        hst_doe = !(&hst_cs_n) && !hst_rd_n;
    end

    p_doe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_rd_n || (&hst_cs_n)) |-> !hst_doe);
endmodule

// File: tb/test_host_mailbox.sv
`timescale 1ns/1ps
module test_host_mailbox;
    localparam int CH = 2;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CH-1:0] hst_cs_n = '1;
    logic          hst_rd_n = 1'b1, hst_wr_n = 1'b1, hst_a0 = 1'b0;
    logic [7:0]    hst_din = '0;
    logic [7:0]    hst_dout;
    logic          hst_doe;
    logic [AW-1:0] loc_addr = '0;
    logic          loc_wr = 1'b0, loc_rd = 1'b0;
    logic [7:0]    loc_wdata = '0;
    logic [7:0]    loc_rdata;
    logic [CH-1:0] loc_irq, obf_pin, ibf_pin;

    always #2.5 clk = ~clk;

    host_mailbox #(.CHANNELS(CH), .SYNC_STAGES(2)) i_host_mailbox (
        .clk(clk), .rst_n(rst_n), .hst_cs_n(hst_cs_n), .hst_rd_n(hst_rd_n),
        .hst_wr_n(hst_wr_n), .hst_a0(hst_a0), .hst_din(hst_din),
        .hst_dout(hst_dout), .hst_doe(hst_doe), .loc_addr(loc_addr),
        .loc_wr(loc_wr), .loc_rd(loc_rd), .loc_wdata(loc_wdata),
        .loc_rdata(loc_rdata), .loc_irq(loc_irq), .obf_pin(obf_pin),
        .ibf_pin(ibf_pin)
    );

    // behavioural model
    bit       m_obf [CH], m_ibf [CH], m_cmd [CH], m_sel [CH];
    bit [7:0] m_in [CH], m_out [CH], m_gp [CH];
    int       m_irq [CH], irq_seen [CH];
    bit       quiet = 1'b0;
    int       checks = 0, fails = 0;

    function automatic bit [7:0] m_stat(int c);
        return m_gp[c] | {4'b0, m_cmd[c], 1'b0, m_ibf[c], m_obf[c]};
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst_n) for (int c = 0; c < CH; c++) if (loc_irq[c]) irq_seen[c]++;
    end

    // per-clock comparison while no access is in flight
    always @(negedge clk) begin
        if (rst_n && quiet) begin
            for (int c = 0; c < CH; c++) begin
                check("R4/R9 ibf_pin", ibf_pin[c], m_ibf[c]);
                check("R5/R9 obf_pin", obf_pin[c], m_obf[c]);
                check("R8/R10 irq count", irq_seen[c], m_irq[c]);
            end
        end
    end

    task automatic host_write(int c, bit a0, bit [7:0] d, int hold);
        @(negedge clk);
        quiet = 1'b0;
        hst_cs_n[c] = 1'b0; hst_a0 = a0; hst_din = d; hst_wr_n = 1'b0;
        repeat (hold) @(negedge clk);
        hst_wr_n = 1'b1; hst_cs_n = '1;
        repeat (7) @(negedge clk);
        m_in[c] = d; m_cmd[c] = a0; m_ibf[c] = 1'b1;
        if (!m_sel[c] || !a0) m_irq[c]++;
        quiet = 1'b1;
    endtask

    task automatic host_read(int c, bit a0, bit [7:0] exp, string tag);
        @(negedge clk);
        quiet = 1'b0;
        hst_cs_n[c] = 1'b0; hst_a0 = a0; hst_rd_n = 1'b0;
        repeat (2) @(negedge clk);
        check({tag, " doe"}, hst_doe, 1);
        check({tag, " dout"}, hst_dout, exp);
        hst_rd_n = 1'b1; hst_cs_n = '1;
        repeat (7) @(negedge clk);
        if (!a0) m_obf[c] = 1'b0;
        quiet = 1'b1;
    endtask

    task automatic slv_write(int c, int ofs, bit [7:0] d);
        @(negedge clk);
        quiet = 1'b0;
        loc_addr = AW'(c * 4 + ofs); loc_wdata = d; loc_wr = 1'b1;
        @(negedge clk);
        loc_wr = 1'b0;
        if (ofs == 0) begin m_out[c] = d; m_obf[c] = 1'b1; end
        if (ofs == 1) m_gp[c] = d & 8'hF4;
        if (ofs == 2) m_sel[c] = d[0];
        quiet = 1'b1;
    endtask

    task automatic slv_read(int c, int ofs, bit [7:0] exp, string tag);
        @(negedge clk);
        quiet = 1'b0;
        loc_addr = AW'(c * 4 + ofs); loc_rd = 1'b1;
        #1 check(tag, loc_rdata, exp);
        @(negedge clk);
        loc_rd = 1'b0;
        if (ofs == 0) m_ibf[c] = 1'b0;
        quiet = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 doe", hst_doe, 0);
        check("R1 irq", loc_irq, 0);
        check("R1 pins", {obf_pin, ibf_pin}, 0);
        for (int c = 0; c < CH; c++)
            for (int o = 0; o < 3; o++) slv_read(c, o, 8'h00, "R1 register");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        quiet = 1'b1;

        // R2 R3 R4 R8: data write, select 0
        host_write(0, 1'b0, 8'hA5, 1);
        slv_read(0, 1, 8'h02, "R3/R4 status after data write");
        slv_read(0, 0, 8'hA5, "R2 inbound byte");
        slv_read(0, 1, 8'h00, "R4 ibf cleared by slave read");
        // command write, select 0 -> interrupt
        host_write(0, 1'b1, 8'h3C, 2);
        slv_read(0, 1, 8'h0A, "R3 command flag set");
        slv_read(0, 0, 8'h3C, "R2 command byte");
        // R8: select 1 masks command writes
        slv_write(0, 2, 8'h01);
        slv_read(0, 2, 8'h01, "R8 control readback");
        host_write(0, 1'b1, 8'h77, 1);
        check("R8 masked command irq", irq_seen[0], m_irq[0]);
        host_write(0, 1'b0, 8'h11, 1);
        slv_read(0, 1, 8'h02, "R3 data flag after data write");
        slv_read(0, 0, 8'h11, "R2 overwrite");

        // R5 R6 R10 on channel 1
        slv_write(1, 0, 8'hC3);
        slv_read(1, 1, 8'h01, "R5 obf set");
        host_read(1, 1'b1, 8'h01, "R6 status read");
        check("R10 status read keeps obf", obf_pin[1], 1);
        host_read(1, 1'b0, 8'hC3, "R6 data read");
        check("R5 obf cleared", obf_pin[1], 0);
        slv_read(1, 1, 8'h00, "R5 status after read");

        // R7: read-only status bits
        host_write(0, 1'b1, 8'h5A, 1);
        slv_write(0, 1, 8'hFF);
        slv_read(0, 1, 8'hFE, "R7 general bits written, ro bits kept");
        slv_write(0, 1, 8'h00);
        slv_read(0, 1, 8'h0A, "R7 ro bits survive clear");

        // R9: channel 1 untouched by channel 0
        slv_read(1, 0, 8'h00, "R9 ch1 inbound");
        slv_read(1, 2, 8'h00, "R9 ch1 control");
        check("R9 ch1 irq count", irq_seen[1], 0);

        // R10: long strobe gives one update
        host_write(1, 1'b0, 8'h96, 25);
        check("R10 one irq for long strobe", irq_seen[1], 1);
        slv_read(1, 0, 8'h96, "R10 long write data");
        // R6: no drive when idle
        check("R6 idle doe", hst_doe, 0);

        quiet = 1'b0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule